// File: doc/BRIEF.md
# Workspace-Register Overlapped Add Pipeline

This block is a small 16-bit processor core that runs a stream of two-operand, register-direct ADD instructions. It has no register file. Its sixteen general registers are 16-bit words in a shared memory, and a workspace pointer locates the block of words that holds them. The core contains that memory as one single-port array with one-cycle synchronous reads. It also holds a program counter, the workspace pointer, a single 16-bit adder for the arithmetic and small adders that form register addresses.

Each ADD needs four memory operations: one instruction read, two operand reads and one result write. The core overlaps work across instructions to keep the memory busy on every cycle of a continuous run of ADDs:
- The add for instruction *i* happens while instruction *i+1* is fetched.
- The result of *i* is written back while *i+1* is decoded.
- The source register address of *i+1* is formed from its low nibble before the opcode is known.
- The destination address is formed while the source word is being read.

A run therefore costs four cycles per ADD plus a fixed two cycles. Those two cycles are the first fetch, which has no add beside it, and the decode of the terminating word.

While the core is idle, a host port gives direct word access to the memory. A host loads the program and the workspace through it, pulses `start` with an entry address and a workspace pointer, waits for `busy` to fall, and then reads the results back.

Top module: `wsp_core`

## Requirements
- R1: Register n of the workspace lives at byte address WP + 2*n (modulo 2^16). Memory word index = byte address shifted right by one and truncated to the index width. Instructions are read at the program counter, which starts at `entry_pc` and advances by 2 per instruction.
- R2: Instruction encoding: bits [15:12] are the opcode, with 4'hA meaning ADD. Bits [7:4] select the destination register, bits [3:0] select the source register, and bits [11:8] are ignored. ADD writes (dst + src) mod 2^16 to the destination register.
- R3: A run of N ADDs ended by a terminating word keeps `busy` high for exactly 4N+2 cycles.
- R4: When an ADD reads a register written by the ADD just before it, it sees the newly written value.
- R5: An ADD whose source and destination are the same register doubles that register.
- R6: After each ADD, `carry` holds the carry out of bit 15 and `zero` is high when the 16-bit result is zero. Both keep their value until the next ADD.
- R7: Any opcode other than 4'hA and 4'h0 halts the core with `illegal` and `halted` high. The preceding ADD still completes, and no later instruction executes.
- R8: Opcode 4'h0 stops the core with `halted` high and `illegal` low. A program made only of this word takes 2 busy cycles.
- R9: After reset, `busy`, `halted`, `illegal`, `carry` and `zero` are all low.
- R10: While the core is idle, `host_we` writes `host_wdata` to word `host_idx`. A read of word `host_idx` appears on `host_rdata` one cycle after the index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin execution (sampled while idle) |
| entry_pc | input | 16 | Byte address of the first instruction |
| ws_base | input | 16 | Workspace pointer (byte address of register 0) |
| host_we | input | 1 | Host write enable, honoured while idle |
| host_idx | input | 8 | Host word index |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Memory read data, one cycle after the index |
| busy | output | 1 | Core is executing |
| halted | output | 1 | Core stopped on a terminating or illegal word |
| illegal | output | 1 | Core stopped on an unknown opcode |
| carry | output | 1 | Carry out of the most recent ADD |
| zero | output | 1 | Most recent ADD result was zero |

## Verification
Two things share a cycle in this block. The write-back of one ADD coincides with the decode and speculative source-address formation of the next. The add itself coincides with the fetch of the following instruction. The bench provokes the risky case with back-to-back ADDs in which each source is the previous destination, including a self-add. If the written value were not in memory before the next operand read, the final register contents would differ from a sequential model. It judges the overlap by comparing every workspace word after the run against that model and by requiring the busy count to equal exactly 4N+2.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_ADD  = 4'hA;
  localparam logic [OPW-1:0] OP_STOP = 4'h0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_SRC,
    ST_DST
  } seq_state_t;
endpackage

// File: rtl/wsp_rst_sync.sv
module wsp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 2'b00;
    else        sr_q <= {sr_q[0], 1'b1};
  end

  assign rst_sync_n = sr_q[1];
endmodule

// File: rtl/wsp_mem.sv
module wsp_mem #(
  parameter int DW    = 16,
  parameter int WORDS = 256,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] arr [WORDS];

  // one port: a cycle either writes or reads, read data valid next cycle
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) arr[idx] <= wdata;
      else    rdata    <= arr[idx];
    end
  end
endmodule

// File: rtl/wsp_addr_gen.sv
module wsp_addr_gen #(
  parameter int DW = 16,
  parameter int RB = 4
) (
  input  logic [DW-1:0] wp,
  input  logic [RB-1:0] reg_no,
  output logic [DW-1:0] addr
);
  // R1: byte address of a workspace register = WP + 2*n
  always_comb addr = wp + DW'({reg_no, 1'b0});
endmodule

// File: rtl/wsp_alu.sv
module wsp_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum,
  output logic          carry,
  output logic          zero
);
  always_comb begin
    {carry, sum} = {1'b0, a} + {1'b0, b};
    zero         = (sum == '0);
  end
endmodule

// File: rtl/wsp_seq.sv
module wsp_seq
  import wsp_pkg::*;
#(
  parameter int DW = 16,
  parameter int RB = 4,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          start,
  input  logic [DW-1:0] entry_pc,
  input  logic [DW-1:0] ws_base,
  input  logic          host_we,
  input  logic [IW-1:0] host_idx,
  input  logic [DW-1:0] host_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] src_addr,
  input  logic [DW-1:0] dst_addr,
  input  logic [DW-1:0] alu_sum,
  input  logic          alu_carry,
  input  logic          alu_zero,
  output logic          mem_en,
  output logic          mem_we,
  output logic [IW-1:0] mem_idx,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] wp,
  output logic [RB-1:0] dst_field,
  output logic [DW-1:0] src_val,
  output logic          busy,
  output logic          halted,
  output logic          illegal,
  output logic          carry,
  output logic          zero
);
  seq_state_t    st_q, st_d;
  logic [DW-1:0] pc_q, pc_d;
  logic [DW-1:0] wp_q, wp_d;
  logic [RB-1:0] df_q, df_d;
  logic [DW-1:0] sa_q, sa_d;
  logic [DW-1:0] da_q, da_d;
  logic [DW-1:0] sv_q, sv_d;
  logic [DW-1:0] res_q, res_d;
  logic          pend_q, pend_d;
  logic          halt_q, halt_d;
  logic          ill_q, ill_d;
  logic          cy_q, cy_d;
  logic          z_q, z_d;
  logic [OPW-1:0] opcode;

  assign opcode = mem_rdata[DW-1 -: OPW];

  // next-state and memory port control
  always_comb begin
    st_d = st_q;   pc_d = pc_q;   wp_d = wp_q;   df_d = df_q;
    sa_d = sa_q;   da_d = da_q;   sv_d = sv_q;   res_d = res_q;
    pend_d = pend_q; halt_d = halt_q; ill_d = ill_q;
    cy_d = cy_q;   z_d = z_q;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_idx   = host_idx;
    mem_wdata = host_wdata;
    unique case (st_q)
      ST_IDLE: begin
        // R10: host owns the port while idle
        mem_en = 1'b1;
        mem_we = host_we;
        if (start) begin
          st_d   = ST_FETCH;
          pc_d   = entry_pc;
          wp_d   = ws_base;
          pend_d = 1'b0;
          halt_d = 1'b0;
          ill_d  = 1'b0;
        end
      end
      ST_FETCH: begin
        // fetch next word; the previous ADD's destination word is on rdata
        mem_en  = 1'b1;
        mem_idx = IW'(pc_q >> 1);
        pc_d    = pc_q + DW'(2);
        if (pend_q) begin
          res_d = alu_sum;
          cy_d  = alu_carry;
          z_d   = alu_zero;
        end
        st_d = ST_DECODE;
      end
      ST_DECODE: begin
        // decode the fetched word while the previous result is written
        df_d = mem_rdata[2*RB-1:RB];
        sa_d = src_addr;              // speculative, before the opcode is known
        if (pend_q) begin
          mem_en    = 1'b1;
          mem_we    = 1'b1;
          mem_idx   = IW'(da_q >> 1);
          mem_wdata = res_q;
        end
        pend_d = 1'b0;
        if (opcode == OP_ADD) begin
          st_d = ST_SRC;
        end else if (opcode == OP_STOP) begin
          st_d   = ST_IDLE;
          halt_d = 1'b1;
        end else begin
          st_d   = ST_IDLE;
          halt_d = 1'b1;
          ill_d  = 1'b1;
        end
      end
      ST_SRC: begin
        mem_en  = 1'b1;
        mem_idx = IW'(sa_q >> 1);
        da_d    = dst_addr;           // formed while the source is read
        st_d    = ST_DST;
      end
      ST_DST: begin
        mem_en  = 1'b1;
        mem_idx = IW'(da_q >> 1);
        sv_d    = mem_rdata;          // source word arrives now
        pend_d  = 1'b1;
        st_d    = ST_FETCH;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pc_q   <= '0;
      wp_q   <= '0;
      df_q   <= '0;
      sa_q   <= '0;
      da_q   <= '0;
      sv_q   <= '0;
      res_q  <= '0;
      pend_q <= 1'b0;
      halt_q <= 1'b0;
      ill_q  <= 1'b0;
      cy_q   <= 1'b0;
      z_q    <= 1'b0;
    end else begin
      st_q   <= st_d;
      pc_q   <= pc_d;
      wp_q   <= wp_d;
      df_q   <= df_d;
      sa_q   <= sa_d;
      da_q   <= da_d;
      sv_q   <= sv_d;
      res_q  <= res_d;
      pend_q <= pend_d;
      halt_q <= halt_d;
      ill_q  <= ill_d;
      cy_q   <= cy_d;
      z_q    <= z_d;
    end
  end

  assign wp        = wp_q;
  assign dst_field = df_q;
  assign src_val   = sv_q;
  assign busy      = (st_q != ST_IDLE);
  assign halted    = halt_q;
  assign illegal   = ill_q;
  assign carry     = cy_q;
  assign zero      = z_q;

  // R3: fixed four-cycle slot order
  a_r3_fetch_then_decode: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_FETCH) |=> (st_q == ST_DECODE));
  a_r3_src_then_dst: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_SRC) |=> (st_q == ST_DST));
  a_r3_dst_then_fetch: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_DST) |=> (st_q == ST_FETCH));
  // R1: program counter advances one word per fetch
  a_r1_pc_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_DECODE) |-> (pc_q == $past(pc_q) + DW'(2)));
  // R2: the result written back is the sum of the two operand words
  a_r2_wb_sum: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_DECODE && pend_q) |-> (mem_we && res_q == $past(mem_rdata + sv_q)));
  // R7: an illegal stop leaves the core halted and idle
  a_r7_illegal_halts: assert property (@(posedge clk) disable iff (!rst_ni)
    ill_q |-> (halt_q && st_q == ST_IDLE));
endmodule

// File: rtl/wsp_core.sv
module wsp_core #(
  parameter int DW        = 16,
  parameter int MEM_WORDS = 256,
  parameter int RB        = 4,
  localparam int IW       = $clog2(MEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] entry_pc,
  input  logic [DW-1:0] ws_base,
  input  logic          host_we,
  input  logic [IW-1:0] host_idx,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          busy,
  output logic          halted,
  output logic          illegal,
  output logic          carry,
  output logic          zero
);
  logic          rst_i_n;
  logic          mem_en, mem_we;
  logic [IW-1:0] mem_idx;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [DW-1:0] wp, src_addr, dst_addr, src_val, alu_sum;
  logic [RB-1:0] dst_field;
  logic          alu_carry, alu_zero;

  wsp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  wsp_mem #(.DW(DW), .WORDS(MEM_WORDS)) u_mem (
    .clk   (clk),
    .en    (mem_en),
    .we    (mem_we),
    .idx   (mem_idx),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  // speculative source address from the fixed low field of the word on the bus
  wsp_addr_gen #(.DW(DW), .RB(RB)) u_src_ag (
    .wp     (wp),
    .reg_no (mem_rdata[RB-1:0]),
    .addr   (src_addr)
  );

  wsp_addr_gen #(.DW(DW), .RB(RB)) u_dst_ag (
    .wp     (wp),
    .reg_no (dst_field),
    .addr   (dst_addr)
  );

  wsp_alu #(.DW(DW)) u_alu (
    .a     (mem_rdata),
    .b     (src_val),
    .sum   (alu_sum),
    .carry (alu_carry),
    .zero  (alu_zero)
  );

  wsp_seq #(.DW(DW), .RB(RB), .IW(IW)) u_seq (
    .clk        (clk),
    .rst_ni     (rst_i_n),
    .start      (start),
    .entry_pc   (entry_pc),
    .ws_base    (ws_base),
    .host_we    (host_we),
    .host_idx   (host_idx),
    .host_wdata (host_wdata),
    .mem_rdata  (mem_rdata),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .alu_sum    (alu_sum),
    .alu_carry  (alu_carry),
    .alu_zero   (alu_zero),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_idx    (mem_idx),
    .mem_wdata  (mem_wdata),
    .wp         (wp),
    .dst_field  (dst_field),
    .src_val    (src_val),
    .busy       (busy),
    .halted     (halted),
    .illegal    (illegal),
    .carry      (carry),
    .zero       (zero)
  );

  assign host_rdata = mem_rdata;
endmodule

// File: tb/sim_wsp_core.sv
module sim_wsp_core;
  localparam int PROG_IDX = 8'h20;   // byte 0x0040
  localparam int WS_IDX   = 8'h80;   // byte 0x0100
  localparam int WS2_IDX  = 8'hA0;   // byte 0x0140

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] entry_pc = '0;
  logic [15:0] ws_base = '0;
  logic        host_we = 1'b0;
  logic [7:0]  host_idx = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        busy, halted, illegal, carry, zero;

  int checks = 0;
  int errors = 0;
  logic [15:0] m [16];
  logic [15:0] prog [16];
  logic        ec, ez;

  always #5 clk = ~clk;

  wsp_core u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .entry_pc(entry_pc),
    .ws_base(ws_base), .host_we(host_we), .host_idx(host_idx),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
    .halted(halted), .illegal(illegal), .carry(carry), .zero(zero)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not finish (actual running, expected done)");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input int idx, input logic [15:0] v);
    @(negedge clk);
    host_we = 1'b1; host_idx = 8'(idx); host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input int idx, output logic [15:0] v);
    @(negedge clk);
    host_idx = 8'(idx);
    @(negedge clk);
    v = host_rdata;
  endtask

  task automatic load_ws(input int base);
    for (int r = 0; r < 16; r++) host_write(base + r, m[r]);
  endtask

  task automatic load_prog(input int n);
    for (int i = 0; i < n; i++) host_write(PROG_IDX + i, prog[i]);
  endtask

  function automatic logic [15:0] enc_add(input int d, input int s);
    return {4'hA, 4'h0, 4'(d), 4'(s)};
  endfunction

  task automatic model_add(input int d, input int s);
    logic [16:0] t;
    t = {1'b0, m[d]} + {1'b0, m[s]};
    m[d] = t[15:0];
    ec = t[16];
    ez = (t[15:0] == 16'h0);
  endtask

  task automatic run(input logic [15:0] wsb, output int cyc);
    cyc = 0;
    @(negedge clk);
    entry_pc = 16'(PROG_IDX * 2); ws_base = wsb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && cyc < 5000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic check_ws(input string req, input int base);
    logic [15:0] v;
    for (int r = 0; r < 16; r++) begin
      host_read(base + r, v);
      chk(req, v, m[r]);
    end
  endtask

  task automatic t_reset();
    chk("R9 busy", 16'(busy), 16'd0);
    chk("R9 halted", 16'(halted), 16'd0);
    chk("R9 illegal", 16'(illegal), 16'd0);
    chk("R9 carry", 16'(carry), 16'd0);
    chk("R9 zero", 16'(zero), 16'd0);
  endtask

  task automatic t_host();
    logic [15:0] v;
    host_write(8'h10, 16'h5A5A);
    host_write(8'h11, 16'hC3C3);
    host_read(8'h10, v);
    chk("R10 host readback", v, 16'h5A5A);
    host_read(8'h11, v);
    chk("R10 host readback", v, 16'hC3C3);
  endtask

  // R1 R2 R3 R4 R5 R8: dependent chain of six adds
  task automatic t_chain();
    int cyc;
    for (int r = 0; r < 16; r++) m[r] = 16'(r * 16'h0111 + 3);
    load_ws(WS_IDX);
    prog[0] = enc_add(1, 2);
    prog[1] = 16'hA531;            // ADD R3,R1 with bits [11:8] nonzero (R2)
    prog[2] = enc_add(1, 3);
    prog[3] = enc_add(15, 0);
    prog[4] = enc_add(0, 15);
    prog[5] = enc_add(2, 2);
    prog[6] = 16'h0000;
    load_prog(7);
    run(16'(WS_IDX * 2), cyc);
    model_add(1, 2); model_add(3, 1); model_add(1, 3);
    model_add(15, 0); model_add(0, 15); model_add(2, 2);
    chk("R3 cycles chain", 16'(cyc), 16'(4 * 6 + 2));
    chk("R8 halted", 16'(halted), 16'd1);
    chk("R8 not illegal", 16'(illegal), 16'd0);
    check_ws("R4 chain register", WS_IDX);
    chk("R6 carry chain", 16'(carry), 16'(ec));
  endtask

  // R6: carry and zero set, then cleared
  task automatic t_flags();
    int cyc;
    m[4] = 16'hFFFF; m[5] = 16'h0001; m[6] = 16'h1234; m[7] = 16'h0001;
    load_ws(WS_IDX);
    prog[0] = enc_add(4, 5); prog[1] = 16'h0000;
    load_prog(2);
    run(16'(WS_IDX * 2), cyc);
    model_add(4, 5);
    chk("R6 carry set", 16'(carry), 16'd1);
    chk("R6 zero set", 16'(zero), 16'd1);
    chk("R2 wrap sum", 16'(ez), 16'd1);
    prog[0] = enc_add(6, 7);
    load_prog(1);
    run(16'(WS_IDX * 2), cyc);
    model_add(6, 7);
    chk("R6 carry clear", 16'(carry), 16'd0);
    chk("R6 zero clear", 16'(zero), 16'd0);
    check_ws("R2 flags register", WS_IDX);
  endtask

  // R5: self add
  task automatic t_double();
    int cyc;
    m[8] = 16'h4321;
    load_ws(WS_IDX);
    prog[0] = enc_add(8, 8); prog[1] = enc_add(8, 8); prog[2] = 16'h0000;
    load_prog(3);
    run(16'(WS_IDX * 2), cyc);
    model_add(8, 8); model_add(8, 8);
    chk("R3 cycles double", 16'(cyc), 16'd10);
    check_ws("R5 self add", WS_IDX);
  endtask

  // R1: relocated workspace, old block untouched
  task automatic t_wp();
    int cyc;
    logic [15:0] old11, v;
    host_read(WS_IDX + 11, old11);
    for (int r = 0; r < 16; r++) m[r] = 16'(16'h1000 + r);
    load_ws(WS2_IDX);
    prog[0] = enc_add(11, 1); prog[1] = enc_add(12, 11); prog[2] = 16'h0000;
    load_prog(3);
    run(16'(WS2_IDX * 2), cyc);
    model_add(11, 1); model_add(12, 11);
    check_ws("R1 relocated workspace", WS2_IDX);
    host_read(WS_IDX + 11, v);
    chk("R1 old workspace untouched", v, old11);
  endtask

  // R7: illegal opcode after one add
  task automatic t_illegal();
    int cyc;
    for (int r = 0; r < 16; r++) m[r] = 16'(r + 16'h0200);
    load_ws(WS_IDX);
    prog[0] = enc_add(1, 2); prog[1] = 16'h5034; prog[2] = enc_add(3, 3);
    prog[3] = 16'h0000;
    load_prog(4);
    run(16'(WS_IDX * 2), cyc);
    model_add(1, 2);
    chk("R7 illegal flag", 16'(illegal), 16'd1);
    chk("R7 halted", 16'(halted), 16'd1);
    chk("R7 cycles", 16'(cyc), 16'd6);
    check_ws("R7 no later execution", WS_IDX);
  endtask

  // R8: stop only
  task automatic t_stop_only();
    int cyc;
    prog[0] = 16'h0000;
    load_prog(1);
    run(16'(WS_IDX * 2), cyc);
    chk("R8 stop-only cycles", 16'(cyc), 16'd2);
    chk("R8 stop-only illegal", 16'(illegal), 16'd0);
    chk("R8 stop-only halted", 16'(halted), 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_host();
    t_chain();
    t_flags();
    t_double();
    t_wp();
    t_illegal();
    t_stop_only();
    summary();
    $finish;
  end
endmodule